// File: doc/BRIEF.md
# Cascaded Programmable Clock Prescaler

This block turns an oscillator clock into a slower master clock by running it through two programmable dividers in series: an input stage with a 2-bit code and an output stage with a 4-bit code. The overall ratio is the product of the two stage ratios. A further stage can halve the master clock to make the CPU clock, and the system clock for peripherals is driven at the CPU clock rate. The stages are counters that run on the oscillator, and the output waveforms are decoded from those counters.

A 2-bit mode field selects the operation. Only the bypass mode produces clocks. The multiplying mode belongs to a loop that is not part of this block, so in that mode the clocks stay low and a flag is raised for the logic that owns the loop. The remaining two mode values count as invalid. Divider codes and the halving select can change at any time, but they take effect only on a period boundary, so a reprogram never cuts a pulse short.

Top module: `osc_prescaler`

## Requirements
- R1: In bypass mode (`mode_sel` = 2'b10) the master clock period is (`in_div_code` + 1) × (`out_div_code` + 1) oscillator cycles.
- R2: `in_div_code` covers 0..3 and `out_div_code` covers 0..14. A value of 15 on `out_div_code` acts as 14, so the slowest ratio is 60.
- R3: With both codes at zero, `mclk` is the oscillator gated by bypass mode, high in the oscillator's high phase and low in its low phase.
- R4: For a ratio N ≥ 2 each master period starts high and stays high for floor(N/2) oscillator cycles, then goes low for the rest of the period.
- R5: `bypass_on`, `pll_req` and `mode_bad` are registered decodes of `mode_sel` (2'b10, 2'b11 and 2'b0x). At most one is high. Whenever the mode is not bypass, from the next edge onward, `mclk`, `cpu_clk` and `sys_clk` are low.
- R6: With `cpu_half_sel` = 0, `cpu_clk` equals `mclk`. With `cpu_half_sel` = 1, `cpu_clk` is high for one master period and low for the next, starting high.
- R7: `sys_clk` always equals `cpu_clk`.
- R8: Changes to the divider codes take effect only on the edge that ends a full master period, so the period in progress finishes with its old ratio.
- R9: Synchronous active-low reset clears the counters and flags and holds all clocks low. The first master period begins on the first oscillator edge that sees `rst_n` high in bypass mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock; all registers run on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | 2'b10 bypass, 2'b11 multiplying loop, 2'b0x invalid |
| in_div_code | input | 2 | Input stage code; stage ratio is code + 1 |
| out_div_code | input | 4 | Output stage code; stage ratio is code + 1, 15 clamped to 14 |
| cpu_half_sel | input | 1 | 1 halves the master clock for the CPU clock |
| mclk | output | 1 | Master clock |
| cpu_clk | output | 1 | CPU clock |
| sys_clk | output | 1 | Peripheral system clock, same rate as the CPU clock |
| bypass_on | output | 1 | Bypass mode active |
| pll_req | output | 1 | Multiplying mode selected; no clocks produced |
| mode_bad | output | 1 | Invalid mode selected |

## Verification
The assertions check on every cycle that the mode flags are mutually exclusive and clear after reset, that the clocks are silent in a non-bypass mode, that the output stage count never goes past 14, and that the active codes stay fixed inside a period. Only the bench's scenarios can show the ratios and high times for each code pair, the duty-preserving divide-by-one path, the CPU halving phase, and the exact moment a mid-period reprogram takes effect. These cases are checked by sampling the clocks in both oscillator phases.

// File: rtl/osc_prescaler_pkg.sv
// Package: shared widths and mode codes for the oscillator prescaler.
// Assumes: the code widths match the stage ranges (input 0..3, output 0..14).
package osc_prescaler_pkg;
    localparam int IDIV_W   = 2;
    localparam int ODIV_W   = 4;
    localparam int ODIV_MAX = 14;
    localparam int RATIO_W  = IDIV_W + ODIV_W;

    typedef enum logic [1:0] {
        MODE_OFF0   = 2'b00,
        MODE_OFF1   = 2'b01,
        MODE_BYPASS = 2'b10,
        MODE_LOOP   = 2'b11
    } mode_e;
endpackage

// File: rtl/presc_stage.sv
// Module: one programmable modulo counter stage of the cascade.
// Counts 0..limit, advancing only when step is high. It holds zero whenever
// run is low or reset is active. last marks the step on which it wraps.
// Assumes: limit stays fixed inside a period (the parent guarantees this).
module presc_stage #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [WIDTH-1:0] limit,
    output logic [WIDTH-1:0] cnt,
    output logic             last
);
    // Wrap marker: this step returns the counter to zero.
    assign last = step && (cnt == limit);

    // Counter update: clear while idle, otherwise advance modulo limit+1.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/presc_shaper.sv
// Module: turns the two stage counts into the master and CPU waveforms.
// The position in the period is out_cnt * in_ratio + in_cnt. The master clock
// is high for the first floor(N/2) positions. A ratio of 1 passes the
// oscillator through, gated by run. The CPU halving phase flips at every
// master wrap, and the halving select is latched only when a CPU period begins.
// Assumes: counts and codes come from presc_stage instances and the code latch.
module presc_shaper #(
    parameter int IDIV_W = 2,
    parameter int ODIV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wrap,
    input  logic              half_sel,
    input  logic [IDIV_W-1:0] act_i,
    input  logic [ODIV_W-1:0] act_o,
    input  logic [IDIV_W-1:0] cnt_i,
    input  logic [ODIV_W-1:0] cnt_o,
    output logic              mclk,
    output logic              cpu_clk
);
    localparam int RATIO_W = IDIV_W + ODIV_W;

    logic [RATIO_W-1:0] ni;
    logic [RATIO_W-1:0] no;
    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] half;
    logic [RATIO_W-1:0] pos;
    logic               phase_hi;
    logic               sel_act;

    // Ratio and position arithmetic for the current period.
    always_comb begin
        ni    = RATIO_W'(act_i) + RATIO_W'(1);
        no    = RATIO_W'(act_o) + RATIO_W'(1);
        ratio = ni * no;
        half  = ratio >> 1;
        pos   = RATIO_W'(cnt_o) * ni + RATIO_W'(cnt_i);
    end

    // Master waveform: pass-through at ratio 1, else high in the first half.
    always_comb begin
        if (!run) begin
            mclk = 1'b0;
        end else if (ratio == RATIO_W'(1)) begin
            mclk = clk;
        end else begin
            mclk = (pos < half);
        end
    end

    // CPU phase: starts high with each run, flips at every master wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_hi <= 1'b1;
        end else if (wrap) begin
            phase_hi <= ~phase_hi;
        end
    end

    // Halving select latch: updated only when a CPU period begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_act <= 1'b0;
        end else if (!run || (wrap && !phase_hi)) begin
            sel_act <= half_sel;
        end
    end

    // CPU waveform select.
    assign cpu_clk = sel_act ? (run && phase_hi) : mclk;
endmodule

// File: rtl/osc_prescaler.sv
// Module: top of the cascaded oscillator prescaler.
// Decodes the mode and latches the divider codes, clamping the output code
// to 14, at the end of each master period or while idle. It chains the input
// and output stages and drives the master, CPU and system clocks.
// Assumes: osc_clk is the only clock; rst_n is synchronous and active low.
module osc_prescaler
    import osc_prescaler_pkg::*;
#(
    parameter int IW   = IDIV_W,
    parameter int OW   = ODIV_W,
    parameter int OMAX = ODIV_MAX
) (
    input  logic          osc_clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel,
    input  logic [IW-1:0] in_div_code,
    input  logic [OW-1:0] out_div_code,
    input  logic          cpu_half_sel,
    output logic          mclk,
    output logic          cpu_clk,
    output logic          sys_clk,
    output logic          bypass_on,
    output logic          pll_req,
    output logic          mode_bad
);
    logic          run_q;
    logic          loop_q;
    logic          bad_q;
    logic [IW-1:0] act_i;
    logic [OW-1:0] act_o;
    logic [IW-1:0] cnt_i;
    logic [OW-1:0] cnt_o;
    logic          last_i;
    logic          wrap;
    logic [OW-1:0] out_clamped;

    // Mode flags: registered decode of the mode field.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            loop_q <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            run_q  <= (mode_sel == MODE_BYPASS);
            loop_q <= (mode_sel == MODE_LOOP);
            bad_q  <= !mode_sel[1];
        end
    end

    // Output code clamp: codes above the maximum act as the maximum.
    assign out_clamped = (out_div_code > OW'(OMAX)) ? OW'(OMAX) : out_div_code;

    // Code latch: load while idle or on the edge that ends a period.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) begin
            act_i <= '0;
            act_o <= '0;
        end else if (!run_q || wrap) begin
            act_i <= in_div_code;
            act_o <= out_clamped;
        end
    end

    presc_stage #(.WIDTH(IW)) u_stage_in (
        .clk   (osc_clk),
        .rst_n (rst_n),
        .run   (run_q),
        .step  (1'b1),
        .limit (act_i),
        .cnt   (cnt_i),
        .last  (last_i)
    );

    presc_stage #(.WIDTH(OW)) u_stage_out (
        .clk   (osc_clk),
        .rst_n (rst_n),
        .run   (run_q),
        .step  (last_i),
        .limit (act_o),
        .cnt   (cnt_o),
        .last  (wrap)
    );

    presc_shaper #(.IDIV_W(IW), .ODIV_W(OW)) u_shaper (
        .clk      (osc_clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .wrap     (wrap),
        .half_sel (cpu_half_sel),
        .act_i    (act_i),
        .act_o    (act_o),
        .cnt_i    (cnt_i),
        .cnt_o    (cnt_o),
        .mclk     (mclk),
        .cpu_clk  (cpu_clk)
    );

    // Peripheral clock runs at the CPU clock rate.
    assign sys_clk   = cpu_clk;
    assign bypass_on = run_q;
    assign pll_req   = loop_q;
    assign mode_bad  = bad_q;
endmodule

// File: rtl/osc_prescaler_chk.sv
// Module: assertion checker bound to osc_prescaler.
// Observes ports and the latched codes, the output stage count and the wrap marker.
module osc_prescaler_chk #(
    parameter int IW   = 2,
    parameter int OW   = 4,
    parameter int OMAX = 14
) (
    input logic          osc_clk,
    input logic          rst_n,
    input logic [1:0]    mode_sel,
    input logic          mclk,
    input logic          cpu_clk,
    input logic          bypass_on,
    input logic          pll_req,
    input logic          mode_bad,
    input logic          wrap,
    input logic [IW-1:0] act_i,
    input logic [OW-1:0] act_o,
    input logic [OW-1:0] cnt_o
);
    // R9: reset leaves every mode flag clear.
    a_r9_reset_flags: assert property (@(posedge osc_clk)
        !rst_n |=> (!bypass_on && !pll_req && !mode_bad));

    // R5: mode flags are mutually exclusive.
    a_r5_flags_onehot: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $onehot0({bypass_on, pll_req, mode_bad}));

    // R5: loop mode raises its flag and silences the clocks.
    a_r5_loop_silent: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (mode_sel == 2'b11) |=> (pll_req && !mclk && !cpu_clk));

    // R5: invalid modes raise their flag and silence the clocks.
    a_r5_bad_silent: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (!mode_sel[1]) |=> (mode_bad && !mclk && !cpu_clk));

    // R2: the output stage never counts past the clamped maximum.
    a_r2_out_range: assert property (@(posedge osc_clk) disable iff (!rst_n)
        cnt_o <= OW'(OMAX));

    // R8: the active codes hold for the whole period.
    a_r8_codes_hold: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (bypass_on && !wrap) |=> ($stable(act_i) && $stable(act_o)));
endmodule

bind osc_prescaler osc_prescaler_chk #(.IW(IW), .OW(OW), .OMAX(OMAX)) u_chk (
    .osc_clk   (osc_clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .mclk      (mclk),
    .cpu_clk   (cpu_clk),
    .bypass_on (bypass_on),
    .pll_req   (pll_req),
    .mode_bad  (mode_bad),
    .wrap      (wrap),
    .act_i     (act_i),
    .act_o     (act_o),
    .cnt_o     (cnt_o)
);

// File: tb/osc_prescaler_test.sv
// Bench: walks a vector table of divider settings, then runs directed tests
// for reset, the non-bypass modes and a reprogram in the middle of a period.
module osc_prescaler_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    // Each vector is {in code[1:0], out code[3:0], halving select}.
    localparam logic [6:0] VEC [NVEC] = '{
        {2'd0, 4'd0,  1'b0},
        {2'd0, 4'd0,  1'b1},
        {2'd1, 4'd0,  1'b0},
        {2'd0, 4'd2,  1'b0},
        {2'd2, 4'd4,  1'b1},
        {2'd1, 4'd2,  1'b1},
        {2'd3, 4'd14, 1'b0},
        {2'd3, 4'd15, 1'b0},
        {2'd2, 4'd1,  1'b1}
    };

    logic       osc_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b10;
    logic [1:0] in_div_code = '0;
    logic [3:0] out_div_code = '0;
    logic       cpu_half_sel = 1'b0;
    logic       mclk, cpu_clk, sys_clk, bypass_on, pll_req, mode_bad;
    int         n_chk = 0;
    int         n_fail = 0;

    always #(CLK_PERIOD/2) osc_clk = ~osc_clk;

    osc_prescaler uut (
        .osc_clk      (osc_clk),
        .rst_n        (rst_n),
        .mode_sel     (mode_sel),
        .in_div_code  (in_div_code),
        .out_div_code (out_div_code),
        .cpu_half_sel (cpu_half_sel),
        .mclk         (mclk),
        .cpu_clk      (cpu_clk),
        .sys_clk      (sys_clk),
        .bypass_on    (bypass_on),
        .pll_req      (pll_req),
        .mode_bad     (mode_bad)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // Hold reset with the given settings, then release after a falling edge.
    task automatic start(input logic [1:0] ic, input logic [3:0] oc, input logic hs);
        @(negedge osc_clk);
        rst_n = 1'b0; mode_sel = 2'b10;
        in_div_code = ic; out_div_code = oc; cpu_half_sel = hs;
        repeat (2) @(negedge osc_clk);
        rst_n = 1'b1;
    endtask

    task automatic run_vec(input logic [6:0] v);
        int n, oc;
        logic mh, ml, ch, cl;
        oc = (v[4:1] == 4'd15) ? 14 : int'(v[4:1]);
        n = (int'(v[6:5]) + 1) * (oc + 1);
        start(v[6:5], v[4:1], v[0]);
        for (int j = 0; j < 2*n + 4; j++) begin
            mh = (n == 1) ? 1'b1 : ((j % n) < (n / 2));
            ml = (n == 1) ? 1'b0 : mh;
            ch = v[0] ? (((j / n) % 2) == 0) : mh;
            cl = v[0] ? ch : ml;
            @(posedge osc_clk); #1;
            if (j == 0) chk("R5 bypass flag", bypass_on, 1'b1);
            chk((n == 1) ? "R3 mclk high phase" : "R1/R4 mclk", mclk, mh);
            chk("R6 cpu_clk high phase", cpu_clk, ch);
            chk("R7 sys_clk", sys_clk, ch);
            @(negedge osc_clk); #1;
            chk((n == 1) ? "R3 mclk low phase" : "R2/R4 mclk", mclk, ml);
            chk("R6 cpu_clk low phase", cpu_clk, cl);
        end
    endtask

    task automatic idle_mode(input logic [1:0] m);
        @(negedge osc_clk);
        mode_sel = m;
        for (int j = 0; j < 6; j++) begin
            @(posedge osc_clk); #1;
            chk("R5 flag pll", pll_req, m == 2'b11);
            chk("R5 flag bad", mode_bad, !m[1]);
            chk("R5 flag bypass", bypass_on, 1'b0);
            chk("R5 mclk silent", mclk, 1'b0);
            chk("R5 cpu silent", cpu_clk, 1'b0);
            @(negedge osc_clk); #1;
            chk("R5 mclk silent low", mclk, 1'b0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R9: reset state after a few edges with reset held.
        repeat (3) @(posedge osc_clk);
        #1;
        chk("R9 reset mclk", mclk, 1'b0);
        chk("R9 reset cpu", cpu_clk, 1'b0);
        chk("R9 reset sys", sys_clk, 1'b0);
        chk("R9 reset flags", bypass_on | pll_req | mode_bad, 1'b0);
        @(negedge osc_clk); #1;
        chk("R9 reset mclk low phase", mclk, 1'b0);

        for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

        // R5: loop mode and both invalid codes, from a running divider.
        idle_mode(2'b11);
        idle_mode(2'b00);
        idle_mode(2'b01);

        // R8: ratio 4 running, reprogram to ratio 2 during the first period.
        start(2'd0, 4'd3, 1'b0);
        for (int j = 0; j < 12; j++) begin
            @(posedge osc_clk); #1;
            chk("R8 period completes", mclk, (j < 4) ? ((j % 4) < 2) : (((j - 4) % 2) == 0));
            if (j == 1) begin
                @(negedge osc_clk);
                out_div_code = 4'd1;
            end
        end

        // R9: reset mid-run silences the clocks on the next edge.
        @(negedge osc_clk);
        rst_n = 1'b0;
        @(posedge osc_clk); #1;
        chk("R9 reset mid-run mclk", mclk, 1'b0);
        chk("R9 reset mid-run flag", bypass_on, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule